// File: doc/BRIEF.md
# Modular Polynomial Accumulate Engine

The engine builds a set of K result polynomials t[i], where each one is its seed polynomial e[i] plus the sum over j of K product polynomials P[i][j]. Every coefficient is reduced modulo Q = 3329. A polynomial holds 256 coefficients of 12 bits. An upstream multiplier streams the product coefficients in one at a time, each with a valid strobe. Within a term the coefficient index changes fastest. After that comes the column j, and the row i changes slowest.

For each accepted coefficient, the engine adds the current addend modulo Q and writes the sum into the accumulator memory at row*256 + index. For column 0 the addend is the seed coefficient. For later columns it is the running sum read back from the accumulator memory. Both internal memories return read data one cycle after the address is presented. The engine therefore presents the address of the coefficient it will consume next. While a coefficient is being accepted, that address is one position ahead of the one being written. The seed-or-running-sum select is delayed by one register so that it lines up with the read data.

Software loads the seed memory through a write port before a run. It reads the finished results through a read port while the engine is idle.

Top module: `pacc_engine`

## Requirements
- R1: After reset, busy_o and done_o are low.
- R2: A start pulse while idle latches k_cfg (the number of rows and columns; 2, 3 or 4) and raises busy_o at the next clock edge. A start pulse while busy is ignored and does not disturb the run in progress.
- R3: Product coefficients are consumed in the order index 0..255 inside a term, then column 0..K-1, then row 0..K-1. Coefficient n of term (i,j) is added into t[i][n].
- R4: Each written value is (addend + product) mod 3329, formed from operands below 3329 with one conditional subtraction. This holds for sums equal to exactly 3329 and for sums up to 6656.
- R5: For column 0 the addend is the seed coefficient e[i][n], written beforehand through seed_we at address seed_waddr = row*256 + n. For later columns the addend is the running t[i][n]. Each final t[i][n] equals (e[i][n] + sum over j of P[i][j][n]) mod 3329.
- R6: prod_valid may be high from the first cycle after the start pulse, with any number of idle cycles between coefficients. This covers back-to-back coefficients, the repeating one-idle-then-two-valid cadence and irregular gaps.
- R7: done_o is high for exactly one cycle. That cycle is the one after the coefficient of row K-1, column K-1, index 255 is accepted, and busy_o is low in that same cycle. done_o is never high earlier in the run.
- R8: While idle, res_rdata shows the accumulator content at res_raddr = row*256 + n. The data appears one cycle after the address is presented.
- R9: prod_valid and prod_coef have no effect on the accumulator memory while the engine is idle.
- R10: In any cycle with an accumulator write, the accumulator read address differs from the write address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| k_cfg | input | 3 | Number of rows and columns K for the run (2, 3 or 4) |
| prod_valid | input | 1 | Product coefficient strobe |
| prod_coef | input | 12 | Product coefficient, below 3329 |
| seed_we | input | 1 | Seed memory write enable |
| seed_waddr | input | 10 | Seed write address, row*256 + index |
| seed_wdata | input | 12 | Seed coefficient, below 3329 |
| res_raddr | input | 10 | Result read address while idle, row*256 + index |
| res_rdata | output | 12 | Result coefficient, one cycle after the address |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse after the final write |

## Verification
The bench drives the stream back-to-back, with the idle/valid/valid cadence and with random gaps. A read-ahead that failed to advance on an accepted coefficient would feed the addend for the wrong index, and every result would be shifted. Runs with K = 3 and K = 4 test the deep running-sum path and the switch from one row to the next. A seed select applied one cycle early or late would add the seed twice, or add a stale sum, at the start of each row. Directed data pins sums at exactly 3329 and at 6656, where a wrong comparison or a missing subtraction returns values of 3329 or more. A start pulse injected mid-run checks that the run is not restarted. Product strobes sent while idle check that the stored results are not corrupted.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

    localparam int unsigned COEF_W = 12;
    localparam int unsigned N_COEF = 256;
    localparam int unsigned IDX_W  = $clog2(N_COEF);
    localparam int unsigned KMIN   = 2;
    localparam int unsigned KMAX   = 4;
    localparam int unsigned ROW_W  = $clog2(KMAX);
    localparam int unsigned KCNT_W = $clog2(KMAX + 1);
    localparam int unsigned ADDR_W = ROW_W + IDX_W;
    localparam int unsigned MOD_Q  = 3329;

    typedef logic [COEF_W-1:0] coef_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [KCNT_W-1:0] kcnt_t;

    // position of one coefficient inside the whole run
    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [ROW_W-1:0] col;
        logic [IDX_W-1:0] idx;
    } pos_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_ACC  = 1'b1
    } state_t;

    // (a + b) mod Q for a, b < Q: one conditional subtract
    function automatic coef_t mod_add(coef_t a, coef_t b);
        logic [COEF_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= (COEF_W+1)'(MOD_Q))
            s = s - (COEF_W+1)'(MOD_Q);
        return s[COEF_W-1:0];
    endfunction

    function automatic kcnt_t clamp_k(kcnt_t kin);
        if (kin < kcnt_t'(KMIN)) return kcnt_t'(KMIN);
        if (kin > kcnt_t'(KMAX)) return kcnt_t'(KMAX);
        return kin;
    endfunction

    function automatic logic is_last(pos_t p, kcnt_t k);
        return (kcnt_t'(p.row) == k - kcnt_t'(1)) &&
               (kcnt_t'(p.col) == k - kcnt_t'(1)) &&
               (p.idx == IDX_W'(N_COEF - 1));
    endfunction

    // successor in index / column / row order; wraps to zero after the last
    function automatic pos_t next_pos(pos_t p, kcnt_t k);
        pos_t n;
        n = p;
        if (p.idx != IDX_W'(N_COEF - 1)) begin
            n.idx = p.idx + IDX_W'(1);
        end else begin
            n.idx = '0;
            if (kcnt_t'(p.col) + kcnt_t'(1) < k) begin
                n.col = p.col + ROW_W'(1);
            end else begin
                n.col = '0;
                if (kcnt_t'(p.row) + kcnt_t'(1) < k)
                    n.row = p.row + ROW_W'(1);
                else
                    n.row = '0;
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/pacc_ram.sv
// One write port, one read port with a registered read (one cycle latency).
module pacc_ram #(
    parameter int unsigned DW = 12,
    parameter int unsigned AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/pacc_seq.sv
// Run control and (row, column, index) sequencing with read-ahead position.
module pacc_seq
    import pacc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  kcnt_t k_cfg,
    input  logic  prod_valid,
    output pos_t  cur_pos,
    output pos_t  rd_pos,
    output logic  busy,
    output logic  done
);
    state_t state;
    kcnt_t  k_q;

    assign busy = (state == ST_ACC);

    // The address presented now is consumed by the next accepted coefficient:
    // one step ahead when a coefficient is taken this cycle.
    always_comb begin
        if (busy && prod_valid)
            rd_pos = next_pos(cur_pos, k_q);
        else
            rd_pos = cur_pos;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            k_q     <= kcnt_t'(KMIN);
            cur_pos <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        k_q   <= clamp_k(k_cfg);
                        state <= ST_ACC;
                    end
                end
                ST_ACC: begin
                    if (prod_valid) begin
                        if (is_last(cur_pos, k_q)) begin
                            state   <= ST_IDLE;
                            done    <= 1'b1;
                            cur_pos <= '0;
                        end else begin
                            cur_pos <= next_pos(cur_pos, k_q);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pacc_accum.sv
// Addend select (delayed to match read latency) and modular add.
module pacc_accum
    import pacc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  seed_sel_next,
    input  coef_t seed_rd,
    input  coef_t acc_rd,
    input  coef_t prod,
    output coef_t sum
);
    logic  seed_sel_q;
    coef_t addend;

    always_ff @(posedge clk) begin
        if (rst)
            seed_sel_q <= 1'b1;
        else
            seed_sel_q <= seed_sel_next;
    end

    assign addend = seed_sel_q ? seed_rd : acc_rd;
    assign sum    = mod_add(addend, prod);
endmodule

// File: rtl/pacc_engine.sv
module pacc_engine
    import pacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [KCNT_W-1:0] k_cfg,
    input  logic              prod_valid,
    input  logic [COEF_W-1:0] prod_coef,
    input  logic              seed_we,
    input  logic [ADDR_W-1:0] seed_waddr,
    input  logic [COEF_W-1:0] seed_wdata,
    input  logic [ADDR_W-1:0] res_raddr,
    output logic [COEF_W-1:0] res_rdata,
    output logic              busy_o,
    output logic              done_o
);
    pos_t  cur_pos;
    pos_t  rd_pos;
    logic  eng_rd;
    addr_t seed_raddr;
    addr_t acc_raddr;
    addr_t acc_waddr;
    logic  acc_we;
    coef_t acc_wdata;
    coef_t seed_rd;
    coef_t acc_rd;

    pacc_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .k_cfg      (k_cfg),
        .prod_valid (prod_valid),
        .cur_pos    (cur_pos),
        .rd_pos     (rd_pos),
        .busy       (busy_o),
        .done       (done_o)
    );

    // engine owns the accumulator read port while running and on the start
    // cycle, so the first coefficient's addend is already registered
    assign eng_rd     = busy_o || start;
    assign seed_raddr = {rd_pos.row, rd_pos.idx};
    assign acc_raddr  = eng_rd ? {rd_pos.row, rd_pos.idx} : res_raddr;
    assign acc_we     = busy_o && prod_valid;
    assign acc_waddr  = {cur_pos.row, cur_pos.idx};

    pacc_ram #(.DW(COEF_W), .AW(ADDR_W)) u_seed_ram (
        .clk   (clk),
        .we    (seed_we),
        .waddr (seed_waddr),
        .wdata (seed_wdata),
        .raddr (seed_raddr),
        .rdata (seed_rd)
    );

    pacc_ram #(.DW(COEF_W), .AW(ADDR_W)) u_acc_ram (
        .clk   (clk),
        .we    (acc_we),
        .waddr (acc_waddr),
        .wdata (acc_wdata),
        .raddr (acc_raddr),
        .rdata (acc_rd)
    );

    pacc_accum u_accum (
        .clk           (clk),
        .rst           (rst),
        .seed_sel_next (rd_pos.col == '0),
        .seed_rd       (seed_rd),
        .acc_rd        (acc_rd),
        .prod          (prod_coef),
        .sum           (acc_wdata)
    );

    assign res_rdata = acc_rd;
endmodule

// File: rtl/pacc_checker.sv
module pacc_checker
    import pacc_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  start,
    input logic  busy,
    input logic  done,
    input logic  we,
    input addr_t waddr,
    input addr_t raddr,
    input coef_t wdata
);
    // R10: read-ahead keeps read and write apart
    a_r10_no_alias: assert property (@(posedge clk) disable iff (rst)
        we |-> (raddr != waddr));

    // R7: done is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: run is over when done is seen
    a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R4: every stored value is reduced
    a_r4_reduced: assert property (@(posedge clk) disable iff (rst)
        we |-> (wdata < coef_t'(MOD_Q)));

    // R2: start from idle begins a run
    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R3: inside a term, successive writes step by one index
    a_r3_write_step: assert property (@(posedge clk) disable iff (rst)
        (we && $past(we) && ($past(waddr[IDX_W-1:0]) != IDX_W'(N_COEF - 1)))
        |-> (waddr == $past(waddr) + addr_t'(1)));
endmodule

bind pacc_engine pacc_checker u_pacc_checker (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy_o),
    .done  (done_o),
    .we    (acc_we),
    .waddr (acc_waddr),
    .raddr (acc_raddr),
    .wdata (acc_wdata)
);

// File: tb/test_pacc_engine.sv
module test_pacc_engine;
    import pacc_pkg::*;

    localparam int Q = 3329;

    logic              clk = 1'b0;
    logic              rst;
    logic              start;
    logic [KCNT_W-1:0] k_cfg;
    logic              prod_valid;
    logic [COEF_W-1:0] prod_coef;
    logic              seed_we;
    logic [ADDR_W-1:0] seed_waddr;
    logic [COEF_W-1:0] seed_wdata;
    logic [ADDR_W-1:0] res_raddr;
    logic [COEF_W-1:0] res_rdata;
    logic              busy_o;
    logic              done_o;

    always #5 clk = ~clk;

    pacc_engine i_pacc_engine (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .k_cfg      (k_cfg),
        .prod_valid (prod_valid),
        .prod_coef  (prod_coef),
        .seed_we    (seed_we),
        .seed_waddr (seed_waddr),
        .seed_wdata (seed_wdata),
        .res_raddr  (res_raddr),
        .res_rdata  (res_rdata),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 0;

    int e_ref [KMAX][N_COEF];
    int p_ref [KMAX][KMAX][N_COEF];
    int t_ref [KMAX][N_COEF];

    task automatic chk(bit ok, string req, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int madd(int a, int b);
        return (a + b) % Q;
    endfunction

    // fill 0: random; 1: all Q-1 (sums up to 2Q-2); 2: sums of exactly Q
    task automatic gen(int k, int fill);
        for (int i = 0; i < k; i++) begin
            for (int n = 0; n < N_COEF; n++) begin
                case (fill)
                    0: e_ref[i][n] = int'($urandom % Q);
                    1: e_ref[i][n] = Q - 1;
                    default: e_ref[i][n] = 1;
                endcase
                for (int j = 0; j < k; j++) begin
                    case (fill)
                        0: p_ref[i][j][n] = int'($urandom % Q);
                        1: p_ref[i][j][n] = Q - 1;
                        default: p_ref[i][j][n] = (j == 0) ? Q - 1 : ((j == 1) ? Q - 1 : 1);
                    endcase
                end
                t_ref[i][n] = e_ref[i][n];
                for (int j = 0; j < k; j++)
                    t_ref[i][n] = madd(t_ref[i][n], p_ref[i][j][n]);
            end
        end
    endtask

    task automatic load_seed(int k);
        for (int i = 0; i < k; i++) begin
            for (int n = 0; n < N_COEF; n++) begin
                seed_we    = 1'b1;
                seed_waddr = ADDR_W'(i * N_COEF + n);
                seed_wdata = COEF_W'(e_ref[i][n]);
                @(negedge clk);
            end
        end
        seed_we = 1'b0;
    endtask

    // mode 0: idle/valid/valid cadence; 1: back-to-back; 2: random gaps
    task automatic run(int k, int mode, bit poke_start);
        int  cnt;
        bit  early_done;
        int  gaps;
        cnt = 0;
        early_done = 0;
        start = 1'b1;
        k_cfg = KCNT_W'(k);
        @(negedge clk);
        start = 1'b0;
        chk(busy_o == 1'b1, "R2 busy after start", int'(busy_o), 1);
        for (int i = 0; i < k; i++) begin
            for (int j = 0; j < k; j++) begin
                for (int n = 0; n < N_COEF; n++) begin
                    if (mode == 0)      gaps = (cnt % 2 == 0) ? 1 : 0;
                    else if (mode == 1) gaps = 0;
                    else                gaps = int'($urandom % 4);
                    for (int g = 0; g < gaps; g++) begin
                        prod_valid = 1'b0;
                        @(negedge clk);
                        if (done_o) early_done = 1;
                    end
                    prod_valid = 1'b1;
                    prod_coef  = COEF_W'(p_ref[i][j][n]);
                    if (poke_start && cnt == 100) begin
                        start = 1'b1;      // R2: must be ignored while busy
                        k_cfg = KCNT_W'(2);
                    end
                    @(negedge clk);
                    start = 1'b0;
                    k_cfg = KCNT_W'(k);
                    cnt++;
                    if (i == k - 1 && j == k - 1 && n == N_COEF - 1) begin
                        chk(done_o == 1'b1, "R7 done after final coefficient", int'(done_o), 1);
                        chk(busy_o == 1'b0, "R7 busy low with done", int'(busy_o), 0);
                    end else if (done_o) begin
                        early_done = 1;
                    end
                end
            end
        end
        prod_valid = 1'b0;
        @(negedge clk);
        chk(done_o == 1'b0, "R7 done lasts one cycle", int'(done_o), 0);
        chk(!early_done, "R7 no early done", int'(early_done), 0);
    endtask

    // R8: address presented at one negedge, data sampled at the next
    task automatic check_results(int k, string tag);
        for (int i = 0; i < k; i++) begin
            for (int n = 0; n < N_COEF; n++) begin
                res_raddr = ADDR_W'(i * N_COEF + n);
                @(negedge clk);
                chk(int'(res_rdata) == t_ref[i][n], tag, int'(res_rdata), t_ref[i][n]);
            end
        end
    endtask

    initial begin
        int seed_val;
        seed_val   = int'($urandom(32'd424242));
        rst        = 1'b1;
        start      = 1'b0;
        k_cfg      = KCNT_W'(2);
        prod_valid = 1'b0;
        prod_coef  = '0;
        seed_we    = 1'b0;
        seed_waddr = '0;
        seed_wdata = '0;
        res_raddr  = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy_o == 1'b0, "R1 busy after reset", int'(busy_o), 0);
        chk(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);

        // K=2, cadence pattern, valid from first cycle after start
        gen(2, 0);
        load_seed(2);
        run(2, 0, 0);
        check_results(2, "R3 R5 R6 R8 R10 K=2 cadence");

        // K=3, back-to-back, stray start mid-run
        gen(3, 0);
        load_seed(3);
        run(3, 1, 1);
        check_results(3, "R2 R5 R6 R10 K=3 back-to-back");

        // K=4 deep accumulate, random gaps
        gen(4, 0);
        load_seed(4);
        run(4, 2, 0);
        check_results(4, "R3 R5 R6 K=4 random gaps");

        // largest operands
        gen(2, 1);
        load_seed(2);
        run(2, 0, 0);
        check_results(2, "R4 sums up to 2Q-2");

        // sums landing exactly on Q
        gen(3, 2);
        load_seed(3);
        run(3, 1, 0);
        check_results(3, "R4 sum equal to Q");

        // R9: strobes while idle leave results intact
        for (int c = 0; c < 40; c++) begin
            prod_valid = 1'b1;
            prod_coef  = COEF_W'($urandom % Q);
            @(negedge clk);
        end
        prod_valid = 1'b0;
        @(negedge clk);
        chk(busy_o == 1'b0, "R9 still idle", int'(busy_o), 0);
        check_results(3, "R9 idle strobes ignored");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL R7 watchdog: actual no completion expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule